// File: doc/BRIEF.md
# Burst Column Address Sequencer

This block walks the column addresses of one synchronous DRAM burst. A controller presents a start column together with a burst length code and an ordering choice, and from the next clock onward the block puts out one column per cycle. It marks each beat as valid and flags the final beat, so the controller knows when it can close the burst or issue the next one. The ordering is either a wrap-around count or an exclusive-or of the start offset with the beat number. In both orderings the walk stays inside the aligned block whose size is the burst length.

A new start column may be accepted on any clock. A start that arrives in mid-burst replaces the running burst, and the new beat 0 appears on the next cycle. A separate abort input ends a burst early without starting another. The column width is a parameter: 9 bits for a 16-bit wide organisation, 10 bits for an 8-bit wide one, and 11 compact bits for a 4-bit wide one. The controller maps the compact bits onto its address pins.

Top module: `burst_col_seq`

## Requirements
- R1: The length code `lenCode` selects the burst length: 2'b00 gives 1 beat, 2'b01 gives 2, 2'b10 gives 4 and 2'b11 gives 8. Column bits at and above log2(length) keep the start column's value on every beat.
- R2: When `ilvMode` is 0 at start (sequential ordering), beat i carries low log2(length) bits equal to (start low bits + i) modulo length.
- R3: When `ilvMode` is 1 at start (interleaved ordering), beat i carries low log2(length) bits equal to start low bits XOR i.
- R4: A `start` sampled on a rising edge makes `beatValid` high with `colOut` equal to `startCol` in the following cycle. Each later beat follows one clock after the one before.
- R5: A `start` sampled while a burst is running discards the rest of that burst. The next cycle shows beat 0 of the new burst, with the length and ordering sampled with the new start.
- R6: With length 1, the start column is put out for exactly one cycle, with `lastBeat` high.
- R7: `lastBeat` is high only together with `beatValid`, and only on beat length−1. If no `start` is sampled on that cycle, `beatValid` is low in the next cycle. A `start` on that cycle continues with no idle cycle between the bursts.
- R8: An `abort` without `start` makes `beatValid` and `lastBeat` low in the next cycle. When `start` and `abort` are high together, `start` wins.
- R9: During and right after reset, `beatValid` is 0, `lastBeat` is 0 and `colOut` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a burst at `startCol` |
| startCol | input | COL_W | Start column |
| lenCode | input | 2 | Burst length code (00=1, 01=2, 10=4, 11=8) |
| ilvMode | input | 1 | 0 = sequential ordering, 1 = interleaved ordering |
| abort | input | 1 | End the running burst |
| colOut | output | COL_W | Column of the current beat |
| beatValid | output | 1 | Current beat is valid |
| lastBeat | output | 1 | Current beat is the final beat |

## Verification
A wrong beat counter shows up on the first beat after a start. It either puts out a column outside the expected order or raises `lastBeat` on the wrong beat. A stale length or ordering register shows up as a wrong sequence or a wrong burst length within at most eight cycles of the start. A lost restart or abort appears one cycle after the request, as an old column or a `beatValid` that stays high. Each burst is compared beat by beat against a column computed in the bench from the start value.

// File: rtl/burst_col_seq_pkg.sv
package burst_col_seq_pkg;

  localparam int OFS_W = 3;

  typedef struct packed {
    logic load;
    logic step;
    logic halt;
  } seqStrobe_t;

  typedef enum logic [1:0] {
    LEN_1 = 2'b00,
    LEN_2 = 2'b01,
    LEN_4 = 2'b10,
    LEN_8 = 2'b11
  } lenCode_t;

  function automatic logic [OFS_W-1:0] lenMaskOf(input logic [1:0] code);
    case (lenCode_t'(code))
      LEN_1:   lenMaskOf = 3'b000;
      LEN_2:   lenMaskOf = 3'b001;
      LEN_4:   lenMaskOf = 3'b011;
      default: lenMaskOf = 3'b111;
    endcase
  endfunction

endpackage

// File: rtl/burst_col_seq_ctrl.sv
module burst_col_seq_ctrl
  import burst_col_seq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             abort,
  input  logic [1:0]       lenCode,
  output seqStrobe_t       strobe,
  output logic [OFS_W-1:0] beatIdx,
  output logic             beatValid,
  output logic             lastBeat
);

  logic             active;
  logic [OFS_W-1:0] lastIdx;
  logic             atEnd;

  assign atEnd = (beatIdx == lastIdx);

  always_comb begin
    strobe      = '0;
    strobe.load = start;
    strobe.halt = !start && (abort || (active && atEnd));
    strobe.step = !start && !abort && active && !atEnd;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active  <= 1'b0;
      beatIdx <= '0;
      lastIdx <= '0;
    end else if (strobe.load) begin
      active  <= 1'b1;
      beatIdx <= '0;
      lastIdx <= lenMaskOf(lenCode);
    end else if (strobe.halt) begin
      active  <= 1'b0;
    end else if (strobe.step) begin
      beatIdx <= beatIdx + 3'd1;
    end
  end

  assign beatValid = active;
  assign lastBeat  = active && atEnd;

endmodule

// File: rtl/burst_col_seq_dp.sv
module burst_col_seq_dp
  import burst_col_seq_pkg::*;
#(
  parameter int COL_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  seqStrobe_t       strobe,
  input  logic [COL_W-1:0] startCol,
  input  logic [1:0]       lenCode,
  input  logic             ilvMode,
  input  logic [OFS_W-1:0] beatIdx,
  output logic [COL_W-1:0] colOut
);

  logic [COL_W-1:0] baseCol;
  logic [OFS_W-1:0] lenMask;
  logic             ilvReg;
  logic [OFS_W-1:0] seqOfs;
  logic [OFS_W-1:0] ilvOfs;
  logic [OFS_W-1:0] ofs;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      baseCol <= '0;
      lenMask <= '0;
      ilvReg  <= 1'b0;
    end else if (strobe.load) begin
      baseCol <= startCol;
      lenMask <= lenMaskOf(lenCode);
      ilvReg  <= ilvMode;
    end
  end

  assign seqOfs = baseCol[OFS_W-1:0] + beatIdx;
  assign ilvOfs = baseCol[OFS_W-1:0] ^ beatIdx;
  assign ofs    = ilvReg ? ilvOfs : seqOfs;

  for (genvar b = 0; b < COL_W; b++) begin : g_bit
    if (b < OFS_W) begin : g_low
      assign colOut[b] = lenMask[b] ? ofs[b] : baseCol[b];
    end else begin : g_high
      assign colOut[b] = baseCol[b];
    end
  end

endmodule

// File: rtl/burst_col_seq.sv
module burst_col_seq
  import burst_col_seq_pkg::*;
#(
  parameter int COL_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [COL_W-1:0] startCol,
  input  logic [1:0]       lenCode,
  input  logic             ilvMode,
  input  logic             abort,
  output logic [COL_W-1:0] colOut,
  output logic             beatValid,
  output logic             lastBeat
);

  seqStrobe_t       strobe;
  logic [OFS_W-1:0] beatIdx;

  burst_col_seq_ctrl u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .abort     (abort),
    .lenCode   (lenCode),
    .strobe    (strobe),
    .beatIdx   (beatIdx),
    .beatValid (beatValid),
    .lastBeat  (lastBeat)
  );

  burst_col_seq_dp #(.COL_W(COL_W)) u_dp (
    .clk      (clk),
    .rst_n    (rst_n),
    .strobe   (strobe),
    .startCol (startCol),
    .lenCode  (lenCode),
    .ilvMode  (ilvMode),
    .beatIdx  (beatIdx),
    .colOut   (colOut)
  );

endmodule

// File: rtl/burst_col_seq_chk.sv
module burst_col_seq_chk #(
  parameter int COL_W = 10
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic [COL_W-1:0] startCol,
  input logic [1:0]       lenCode,
  input logic             abort,
  input logic [COL_W-1:0] colOut,
  input logic             beatValid,
  input logic             lastBeat
);

  p_last_has_valid_r7: assert property (@(posedge clk) disable iff (!rst_n)
    lastBeat |-> beatValid);

  p_start_beat0_r4: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (beatValid && colOut == $past(startCol)));

  p_single_beat_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (start && lenCode == 2'b00) |=> lastBeat);

  p_idle_after_last_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (lastBeat && !start) |=> !beatValid);

  p_abort_stops_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (abort && !start) |=> (!beatValid && !lastBeat));

  p_upper_fixed_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (beatValid && !start) |=> (!beatValid || colOut[COL_W-1:3] == $past(colOut[COL_W-1:3])));

endmodule

bind burst_col_seq burst_col_seq_chk #(.COL_W(COL_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .start     (start),
  .startCol  (startCol),
  .lenCode   (lenCode),
  .abort     (abort),
  .colOut    (colOut),
  .beatValid (beatValid),
  .lastBeat  (lastBeat)
);

// File: tb/burst_col_seq_test.sv
module burst_col_seq_test;

  localparam int COL_W = 10;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             start = 1'b0;
  logic [COL_W-1:0] startCol = '0;
  logic [1:0]       lenCode = 2'b00;
  logic             ilvMode = 1'b0;
  logic             abort = 1'b0;
  logic [COL_W-1:0] colOut;
  logic             beatValid;
  logic             lastBeat;

  int totalChecks = 0;
  int badChecks = 0;

  always #4 clk = ~clk;

  burst_col_seq #(.COL_W(COL_W)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .startCol(startCol),
    .lenCode(lenCode), .ilvMode(ilvMode), .abort(abort),
    .colOut(colOut), .beatValid(beatValid), .lastBeat(lastBeat)
  );

  function automatic int expCol(input int s, input int code, input bit ilv, input int i);
    int m;
    int lo;
    m  = (1 << code) - 1;
    lo = ilv ? ((s & 7) ^ i) : ((s & 7) + i);
    return (s & ~m) | (lo & m);
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    totalChecks++;
    if (!ok) begin
      badChecks++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Apply a start at the next falling edge; return in the cycle showing beat 0.
  task automatic issue(input int col, input int code, input bit ilv, input bit ab);
    @(negedge clk);
    start = 1'b1; startCol = COL_W'(col); lenCode = 2'(code); ilvMode = ilv; abort = ab;
    @(negedge clk);
    start = 1'b0; abort = 1'b0;
  endtask

  // Check all beats; returns while the last beat is visible.
  task automatic expectBeats(input int col, input int code, input bit ilv, input string tag);
    int len;
    len = 1 << code;
    for (int i = 0; i < len; i++) begin
      check(beatValid === 1'b1, {tag, " valid"}, int'(beatValid), 1);
      check(colOut === COL_W'(expCol(col, code, ilv, i)), {tag, " col"},
            int'(colOut), expCol(col, code, ilv, i));
      check(lastBeat === (i == len - 1), {tag, " last"}, int'(lastBeat), int'(i == len - 1));
      if (i < len - 1) @(negedge clk);
    end
  endtask

  task automatic expectIdle(input string tag);
    @(negedge clk);
    check(beatValid === 1'b0 && lastBeat === 1'b0, tag, int'({beatValid, lastBeat}), 0);
  endtask

  task automatic t_reset;
    repeat (3) @(negedge clk);
    check(beatValid === 1'b0 && lastBeat === 1'b0 && colOut === '0, "R9 reset state",
          int'({colOut, beatValid, lastBeat}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(beatValid === 1'b0 && colOut === '0, "R9 after reset", int'({colOut, beatValid}), 0);
  endtask

  task automatic t_burst(input int col, input int code, input bit ilv, input string tag);
    issue(col, code, ilv, 1'b0);
    expectBeats(col, code, ilv, tag);
    expectIdle({tag, " R7 idle after last"});
  endtask

  task automatic t_restart;
    issue(10'h1A3, 3, 1'b0, 1'b0);
    @(negedge clk); @(negedge clk);
    start = 1'b1; startCol = 10'h0F6; lenCode = 2'b10; ilvMode = 1'b1;
    @(negedge clk);
    start = 1'b0;
    expectBeats(10'h0F6, 2, 1'b1, "R5 restart");
    expectIdle("R5 idle after restart");
  endtask

  task automatic t_abort;
    issue(10'h2C4, 3, 1'b0, 1'b0);
    @(negedge clk);
    abort = 1'b1;
    @(negedge clk);
    abort = 1'b0;
    check(beatValid === 1'b0 && lastBeat === 1'b0, "R8 abort ends burst",
          int'({beatValid, lastBeat}), 0);
    issue(10'h111, 3, 1'b0, 1'b0);
    @(negedge clk);
    start = 1'b1; abort = 1'b1; startCol = 10'h35E; lenCode = 2'b01; ilvMode = 1'b0;
    @(negedge clk);
    start = 1'b0; abort = 1'b0;
    expectBeats(10'h35E, 1, 1'b0, "R8 start wins");
    expectIdle("R8 idle");
  endtask

  task automatic t_gapless;
    issue(10'h046, 2, 1'b0, 1'b0);
    expectBeats(10'h046, 2, 1'b0, "R7 first");
    start = 1'b1; startCol = 10'h3F9; lenCode = 2'b11; ilvMode = 1'b1;
    @(negedge clk);
    start = 1'b0;
    expectBeats(10'h3F9, 3, 1'b1, "R7 gapless second");
    expectIdle("R7 idle after gapless");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    badChecks++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", totalChecks, badChecks);
    $finish;
  end

  initial begin
    t_reset();
    t_burst(10'h2D5, 3, 1'b0, "R2 R4 seq len8");
    t_burst(10'h2D5, 3, 1'b1, "R3 ilv len8");
    t_burst(10'h16E, 2, 1'b0, "R2 seq len4");
    t_burst(10'h16E, 2, 1'b1, "R3 ilv len4");
    t_burst(10'h0A7, 1, 1'b0, "R1 seq len2");
    t_burst(10'h0A7, 1, 1'b1, "R1 ilv len2");
    t_burst(10'h3FF, 3, 1'b0, "R1 upper bits fixed");
    t_burst(10'h213, 0, 1'b1, "R6 len1");
    t_restart();
    t_abort();
    t_gapless();
    $display("  test done: total=%0d bad=%0d", totalChecks, badChecks);
    $finish;
  end

endmodule